// File: doc/BRIEF.md
# External Bus Strobe and Address Sequencer

This block sits between an 8-bit controller core and its external memories. It is clocked directly by the oscillator. Each group of 12 oscillator periods forms one machine cycle, made of six states (S1..S6) with two phases each. A slot counter runs from 0 to 11, and slot `2*(s-1)+p-1` is state Ss phase Pp. Program code is always fetched from outside the chip. The block sends the fetch address out over two 8-bit ports and produces the latch pulse (`ale`) and the active-low code read strobe (`psen_n`). The low port (`lo_*`) carries the low address byte and then data on the same pins. The high port (`hi_*`) carries the upper address byte.

When the core requests an external data transfer, the block spends two machine cycles on it. In the first cycle the data address is latched at the S4 pulse. In the second cycle the S1 latch pulse and both code strobes are replaced by an active-low read strobe (`rd_n`) or write strobe (`wr_n`). A transfer can use a 16-bit address, or an 8-bit address in which the high port shows the core's own port register. A reset input passes through a filter and takes effect only after it has been held high long enough.

The control is a three-state machine that advances only at the last slot of a machine cycle. The states are MC_FETCH (plain code fetch), MC_DADDR (first cycle of a data transfer) and MC_DXFER (second cycle, strobe cycle). The transitions are:
- MC_FETCH→MC_DADDR when `xreq` is high.
- MC_FETCH→MC_FETCH otherwise.
- MC_DADDR→MC_DXFER always.
- MC_DXFER→MC_DADDR when `xreq` is high (back-to-back transfers).
- MC_DXFER→MC_FETCH otherwise.

Top module: `xbus_seq`

## Requirements
- R1: In MC_FETCH cycles `ale` is high exactly in slots 1 and 7 (S1P2 and S4P2), giving two pulses per 12 clocks.
- R2: In MC_FETCH cycles `psen_n` is low in slots 2–5 and 8–11 (S2–S3 and S5–S6) and high in all other slots.
- R3: `xreq`, `xwrite`, `xwide`, `xaddr` and `xwdata` are sampled at the end of slot 11 of an MC_FETCH or MC_DXFER cycle. The following cycle is MC_DADDR, in which the low port drives `xaddr[7:0]` in slots 6–7 so that the falling edge of `ale` after slot 7 latches it. `xbusy` is high throughout MC_DADDR and MC_DXFER.
- R4: In MC_DXFER, `ale` stays low in slot 1 and `psen_n` stays high in all slots. Each transfer therefore drops exactly one latch pulse and two code strobes. Slots 6–7 of MC_DXFER again drive the fetch address, with a pulse in slot 7.
- R5: In slots 0–5 of MC_DXFER, `wr_n` is low for a write (`xwrite`=1) and `rd_n` is low for a read. The two strobes are never low together, and neither is low while `ale` is high or `psen_n` is low.
- R6: During a write, `lo_oe` is 1 and `lo_out` equals the latched write byte in every slot in which `wr_n` is low.
- R7: During a read, `lo_oe` is 0 while `rd_n` is low. `lo_in` is captured at the end of slot 5, and `rvalid` is high with `rdata` holding that byte for exactly slot 6 of MC_DXFER.
- R8: From slot 6 of MC_DADDR through slot 5 of MC_DXFER, `hi_out` shows `xaddr[15:8]` when `xwide`=1 and `p2_reg` when `xwide`=0. At all other times it shows `pc_addr[15:8]`.
- R9: `hi_strong` is 1 whenever `hi_out` carries address bits and 0 while it shows `p2_reg` during an 8-bit transfer.
- R10: Outside the strobe window, the low port drives `pc_addr[7:0]` in slots 0–1 and 6–7 (`lo_oe`=1) and releases it (`lo_oe`=0) in every other slot.
- R11: The block enters reset only after `rst` has been sampled high on 24 consecutive rising edges (two machine cycles). A shorter high level, including 23 edges, has no effect on the sequence.
- R12: While in reset, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `lo_oe`=0, `hi_out`=8'hFF, `hi_strong`=0 and `xbusy`=0. The first edge that samples `rst` low releases reset, and the window after that edge is slot 0 of an MC_FETCH cycle.
- R13: A request raised during MC_DXFER starts a new MC_DADDR immediately, with no MC_FETCH cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Raw reset request, filtered |
| pc_addr | input | 16 | Code fetch address from core |
| xreq | input | 1 | Data transfer request |
| xwrite | input | 1 | 1 = write, 0 = read |
| xwide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| xaddr | input | 16 | Data transfer address |
| xwdata | input | 8 | Write byte |
| p2_reg | input | 8 | High port output register contents |
| lo_in | input | 8 | Low port pin input |
| ale | output | 1 | Address latch pulse |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port driver enable |
| hi_out | output | 8 | High port output value |
| hi_strong | output | 1 | High port strong pull-up enable |
| xbusy | output | 1 | Data transfer in progress |
| rdata | output | 8 | Captured read byte |
| rvalid | output | 1 | `rdata` valid pulse |

## Verification
All strobes and port values are combinational from the slot counter and state register, so each one is due in the same clock window as the slot that defines it. The exceptions are three. `rvalid`/`rdata` appear one clock after the final read-strobe slot. A request takes effect one full machine cycle after it is sampled. Reset takes effect after the 24th high edge, and release happens on the first low edge. The bench drives inputs 2 ns after each rising edge and samples at the falling edge. Its driver queues twelve expected slot vectors per machine cycle, and the monitor pops one per falling edge, so each comparison lands in exactly the slot it describes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int PHASES     = 2;
    localparam int STATES     = 6;
    localparam int OSC_PER_MC = PHASES * STATES;
    localparam int CNT_W      = $clog2(OSC_PER_MC);

    // slot positions (slot = 2*(state-1) + phase-1)
    localparam logic [CNT_W-1:0] SL_S1P2  = CNT_W'(1);
    localparam logic [CNT_W-1:0] SL_S2P1  = CNT_W'(2);
    localparam logic [CNT_W-1:0] SL_S3P2  = CNT_W'(5);
    localparam logic [CNT_W-1:0] SL_S4P1  = CNT_W'(6);
    localparam logic [CNT_W-1:0] SL_S4P2  = CNT_W'(7);
    localparam logic [CNT_W-1:0] SL_S5P1  = CNT_W'(8);
    localparam logic [CNT_W-1:0] SL_LAST  = CNT_W'(OSC_PER_MC - 1);

    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_DADDR = 2'd1,
        MC_DXFER = 2'd2
    } mc_t;
endpackage

// File: rtl/xbus_rstfilt.sv
module xbus_rstfilt #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst,
    output logic sys_rst,
    output logic armed
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (!rst) begin
            hold_q  <= '0;
            sys_rst <= 1'b0;
        end else if (hold_q == HW'(HOLD - 1)) begin
            sys_rst <= 1'b1;
        end else begin
            hold_q <= hold_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (sys_rst) armed <= 1'b1;
    end

    // R11
    rst_release_chk: assert property (@(posedge clk) disable iff (!armed)
        !rst |=> !sys_rst);
endmodule

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
    parameter int N = 12
) (
    input  logic                 clk,
    input  logic                 sys_rst,
    output logic [$clog2(N)-1:0] slot,
    output logic                 mc_end
);
    localparam int W = $clog2(N);

    assign mc_end = (slot == W'(N - 1));

    always_ff @(posedge clk) begin
        if (sys_rst || mc_end) slot <= '0;
        else                   slot <= slot + 1'b1;
    end

    // R1
    slot_wrap_chk: assert property (@(posedge clk) disable iff (sys_rst)
        mc_end |=> (slot == '0));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
    parameter int RST_MC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] pc_addr,
    input  logic        xreq,
    input  logic        xwrite,
    input  logic        xwide,
    input  logic [15:0] xaddr,
    input  logic [7:0]  xwdata,
    input  logic [7:0]  p2_reg,
    input  logic [7:0]  lo_in,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    output logic [7:0]  hi_out,
    output logic        hi_strong,
    output logic        xbusy,
    output logic [7:0]  rdata,
    output logic        rvalid
);
    import xbus_pkg::*;

    localparam int HOLD = RST_MC * OSC_PER_MC;

    logic             sys_rst;
    logic             armed;
    logic [CNT_W-1:0] slot;
    logic             mc_end;

    xbus_rstfilt #(.HOLD(HOLD)) u_rst (
        .clk     (clk),
        .rst     (rst),
        .sys_rst (sys_rst),
        .armed   (armed)
    );

    xbus_timebase #(.N(OSC_PER_MC)) u_tb (
        .clk     (clk),
        .sys_rst (sys_rst),
        .slot    (slot),
        .mc_end  (mc_end)
    );

    mc_t         state, nxt;
    logic        d_we, d_wide;
    logic [15:0] d_addr;
    logic [7:0]  d_wdata;

    // state register
    always_ff @(posedge clk) begin
        if (sys_rst)     state <= MC_FETCH;
        else if (mc_end) state <= nxt;
    end

    always_comb begin
        unique case (state)
            MC_FETCH: nxt = xreq ? MC_DADDR : MC_FETCH;
            MC_DADDR: nxt = MC_DXFER;
            MC_DXFER: nxt = xreq ? MC_DADDR : MC_FETCH;
            default:  nxt = MC_FETCH;
        endcase
    end

    // request capture at the end of a cycle that may start a transfer
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            d_we    <= 1'b0;
            d_wide  <= 1'b0;
            d_addr  <= '0;
            d_wdata <= '0;
        end else if (mc_end && xreq && state != MC_DADDR) begin
            d_we    <= xwrite;
            d_wide  <= xwide;
            d_addr  <= xaddr;
            d_wdata <= xwdata;
        end
    end

    // read capture at the last strobe clock
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= (state == MC_DXFER) && (slot == SL_S3P2) && !d_we;
            if ((state == MC_DXFER) && (slot == SL_S3P2) && !d_we) rdata <= lo_in;
        end
    end

    logic       ale_slot, code_slot, addr_win, first_half;
    logic [7:0] d_hi;

    assign ale_slot   = (slot == SL_S1P2) || (slot == SL_S4P2);
    assign code_slot  = ((slot >= SL_S2P1) && (slot <= SL_S3P2)) || (slot >= SL_S5P1);
    assign addr_win   = (slot <= SL_S1P2) || (slot == SL_S4P1) || (slot == SL_S4P2);
    assign first_half = (slot < SL_S4P1);
    assign d_hi       = d_wide ? d_addr[15:8] : p2_reg;

    // outputs
    always_comb begin
        ale       = 1'b0;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        lo_oe     = 1'b0;
        lo_out    = 8'hFF;
        hi_out    = 8'hFF;
        hi_strong = 1'b0;
        xbusy     = 1'b0;
        if (!sys_rst) begin
            xbusy     = (state != MC_FETCH);
            hi_out    = pc_addr[15:8];
            hi_strong = 1'b1;
            lo_out    = pc_addr[7:0];
            unique case (state)
                MC_FETCH: begin
                    ale    = ale_slot;
                    psen_n = !code_slot;
                    lo_oe  = addr_win;
                end
                MC_DADDR: begin
                    ale    = ale_slot;
                    psen_n = !code_slot;
                    lo_oe  = addr_win;
                    if (!first_half) begin
                        lo_out    = d_addr[7:0];
                        hi_out    = d_hi;
                        hi_strong = d_wide;
                    end
                end
                MC_DXFER: begin
                    if (first_half) begin
                        rd_n      = d_we;
                        wr_n      = !d_we;
                        lo_oe     = d_we;
                        lo_out    = d_wdata;
                        hi_out    = d_hi;
                        hi_strong = d_wide;
                    end else begin
                        ale   = (slot == SL_S4P2);
                        lo_oe = addr_win;
                    end
                end
                default: begin
                    ale = 1'b0;
                end
            endcase
        end
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (sys_rst || !armed)
        (rd_n || wr_n) && !((!rd_n || !wr_n) && (ale || !psen_n)));

    // R2
    ale_code_chk: assert property (@(posedge clk) disable iff (sys_rst || !armed)
        !(ale && !psen_n));

    // R6
    wdata_hold_chk: assert property (@(posedge clk) disable iff (sys_rst || !armed)
        (!wr_n && $past(!wr_n)) |-> ($stable(lo_out) && lo_oe));

    // R7
    rd_float_chk: assert property (@(posedge clk) disable iff (sys_rst || !armed)
        !rd_n |-> !lo_oe);

    // R9
    weak_hi_chk: assert property (@(posedge clk) disable iff (sys_rst || !armed)
        !hi_strong |-> xbusy);

    // R7
    rvalid_after_rd_chk: assert property (@(posedge clk) disable iff (sys_rst || !armed)
        rvalid |-> ($past(!rd_n) && rd_n));
endmodule

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
    localparam int CLK_NS = 10;
    localparam int K_FETCH = 0;
    localparam int K_DADDR = 1;
    localparam int K_DXFER = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic [15:0] pc_addr = '0;
    logic        xreq = 1'b0, xwrite = 1'b0, xwide = 1'b0;
    logic [15:0] xaddr = '0;
    logic [7:0]  xwdata = '0;
    logic [7:0]  p2_reg = 8'hC5;
    logic [7:0]  lo_in = '0;
    logic        ale, psen_n, rd_n, wr_n, lo_oe, hi_strong, xbusy, rvalid;
    logic [7:0]  lo_out, hi_out, rdata;

    always #(CLK_NS/2) clk = ~clk;

    xbus_seq u0 (
        .clk(clk), .rst(rst), .pc_addr(pc_addr), .xreq(xreq), .xwrite(xwrite),
        .xwide(xwide), .xaddr(xaddr), .xwdata(xwdata), .p2_reg(p2_reg), .lo_in(lo_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
        .lo_oe(lo_oe), .hi_out(hi_out), .hi_strong(hi_strong), .xbusy(xbusy),
        .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct {
        logic       ale, psen_n, rd_n, wr_n, lo_oe, hi_strong, busy, rvalid;
        logic [7:0] lo_out, hi_out, rdata;
        string      tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    int kind = K_FETCH;
    int rst_left = 0;
    bit done = 0;
    bit c_we = 0, c_wide = 0;
    logic [15:0] c_addr = '0;
    logic [7:0]  c_wdata = '0;

    function automatic item_t expect_slot(int k, logic [15:0] pc, logic [7:0] li, string tg);
        item_t e;
        logic [7:0] dhi;
        dhi = c_wide ? c_addr[15:8] : p2_reg;
        e.ale = 0; e.psen_n = 1; e.rd_n = 1; e.wr_n = 1; e.lo_oe = 0;
        e.lo_out = pc[7:0]; e.hi_out = pc[15:8]; e.hi_strong = 1;
        e.busy = (kind != K_FETCH); e.rvalid = 0; e.rdata = li;
        e.tag = "R10";
        if (kind == K_DXFER && k < 6) begin
            e.rd_n = c_we; e.wr_n = !c_we; e.lo_oe = c_we; e.lo_out = c_wdata;
            e.hi_out = dhi; e.hi_strong = c_wide;
            e.tag = c_we ? "R6" : "R7";
        end else begin
            e.ale = (k == 7) || (k == 1 && kind != K_DXFER);
            e.psen_n = !(kind != K_DXFER && ((k >= 2 && k <= 5) || k >= 8));
            e.lo_oe = (k <= 1) || (k == 6) || (k == 7);
            if (e.ale) e.tag = "R1";
            else if (!e.psen_n) e.tag = "R2";
            if (kind == K_DXFER) begin
                e.tag = "R4";
                e.rvalid = (k == 6) && !c_we;
                if (e.rvalid) e.tag = "R7";
            end
            if (kind == K_DADDR && k >= 6) begin
                if (k <= 7) e.lo_out = c_addr[7:0];
                e.hi_out = dhi; e.hi_strong = c_wide;
                e.tag = (k <= 7) ? "R3" : (c_wide ? "R8" : "R9");
            end
        end
        if (tg != "") e.tag = tg;
        return e;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t e;
            logic ok;
            e = q.pop_front();
            total++;
            ok = (ale === e.ale) && (psen_n === e.psen_n) && (rd_n === e.rd_n) &&
                 (wr_n === e.wr_n) && (lo_oe === e.lo_oe) && (hi_out === e.hi_out) &&
                 (hi_strong === e.hi_strong) && (xbusy === e.busy) && (rvalid === e.rvalid) &&
                 (!e.lo_oe || lo_out === e.lo_out) && (!e.rvalid || rdata === e.rdata);
            if (!ok) begin
                bad++;
                $display("FAIL %s: act ale=%b psen=%b rd=%b wr=%b oe=%b lo=%h hi=%h st=%b bsy=%b rv=%b rd=%h | exp ale=%b psen=%b rd=%b wr=%b oe=%b lo=%h hi=%h st=%b bsy=%b rv=%b rd=%h",
                    e.tag, ale, psen_n, rd_n, wr_n, lo_oe, lo_out, hi_out, hi_strong, xbusy, rvalid, rdata,
                    e.ale, e.psen_n, e.rd_n, e.wr_n, e.lo_oe, e.lo_out, e.hi_out, e.hi_strong, e.busy, e.rvalid, e.rdata);
            end
        end
    end

    // driver: called at the start of slot 0, returns at the start of the next slot 0
    task automatic run_mc(input bit nreq, input bit nwe, input bit nwide,
                          input logic [15:0] na, input logic [7:0] nw,
                          input logic [15:0] pc, input logic [7:0] li,
                          input int rn, input string tg);
        pc_addr = pc; lo_in = li;
        xreq = nreq; xwrite = nwe; xwide = nwide; xaddr = na; xwdata = nw;
        for (int k = 0; k < 12; k++) q.push_back(expect_slot(k, pc, li, tg));
        if (rn > 0) rst_left = rn;
        for (int c = 0; c < 12; c++) begin
            if (rst_left > 0) begin rst = 1'b1; rst_left--; end
            else rst = 1'b0;
            @(posedge clk); #2;
        end
        if (kind == K_DADDR) kind = K_DXFER;
        else if (nreq) begin
            kind = K_DADDR;
            c_we = nwe; c_wide = nwide; c_addr = na; c_wdata = nw;
        end else kind = K_FETCH;
    endtask

    task automatic check_idle(input string tg);
        total++;
        if (!(ale === 1'b0 && psen_n === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1 &&
              lo_oe === 1'b0 && hi_out === 8'hFF && hi_strong === 1'b0 && xbusy === 1'b0)) begin
            bad++;
            $display("FAIL %s: reset outputs act ale=%b psen=%b rd=%b wr=%b oe=%b hi=%h st=%b bsy=%b exp 0 1 1 1 0 ff 0 0",
                tg, ale, psen_n, rd_n, wr_n, lo_oe, hi_out, hi_strong, xbusy);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #2; rst = 1'b1;
        repeat (26) @(posedge clk);
        @(negedge clk);
        check_idle("R12");
        @(posedge clk); #2; rst = 1'b0;
        @(posedge clk); #2;
        kind = K_FETCH;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        // R12 first cycle after release starts at slot 0
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h1234, 8'h00, 0, "R12");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'hA5F0, 8'h00, 0, "");
        // wide read (R3, R7, R8)
        run_mc(1, 0, 1, 16'h5A3C, 8'h00, 16'h0102, 8'h00, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h0103, 8'h00, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h0104, 8'h9E, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h0105, 8'h00, 0, "");
        // narrow write (R6, R9), then back-to-back wide write (R13)
        run_mc(1, 1, 0, 16'h0077, 8'h3B, 16'h2200, 8'h00, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h2201, 8'h00, 0, "");
        run_mc(1, 1, 1, 16'hE1D2, 8'hC4, 16'h2202, 8'h00, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h2203, 8'h00, 0, "R13");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h2204, 8'h00, 0, "R13");
        // narrow read
        run_mc(1, 0, 0, 16'h00F3, 8'h00, 16'h3300, 8'h00, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h3301, 8'h00, 0, "");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h3302, 8'h61, 0, "");
        // R11: 23 high edges must not reset
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h4400, 8'h00, 23, "R11");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h4401, 8'h00, 0, "R11");
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h4402, 8'h00, 0, "R11");
        // full reset again
        do_reset();
        run_mc(0, 0, 0, 16'h0, 8'h0, 16'h7788, 8'h00, 0, "R12");
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: act running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule